// File: doc/BRIEF.md
# Digit-Serial Base (-1+j) Complex Adder

This block adds two complex numbers that are each held as a single binary word in the radix (-1+j) system. In that system a word of digits d_k, each 0 or 1, stands for the sum of d_k·(-1+j)^k. Both operands enter from the least significant end, two digits of each per clock. Every accepted digit pair yields two result digits. What is left over is an eight-digit carry pattern, held in a register and folded into the next pair. Adding a one to a one does not give a single carry bit here: it gives a zero digit plus ones in the second and third positions above it. The register therefore has to hold a short digit string, not one bit.

To run an add, a caller presents the pairs on consecutive or spaced cycles. The first pair is flagged with the start input, which replaces the held carry with zero. The caller collects the two-digit sums as they come out. After the last pair it raises the carry-out enable. The full result is the carry pattern followed by the collected digit pairs, most significant pair last in time. An add of n digits takes n/2 accepted pairs. Two variants are available: a table built at elaboration, or the same function evaluated as logic.

Top module: `cbn_serial_adder`

## Requirements
- R1: After reset, sum_valid_o is 0 and the held carry is 00000000, so carry_o reads 0 even with the enable high.
- R2: The outputs for a pair depend on a_i and b_i only through their per-position digit counts, so swapping a_i and b_i gives identical sum_o and carry.
- R3: One clock after a pair is accepted (valid_i high), sum_valid_o is 1. sum_o[0] and sum_o[1] hold the digits of weight (-1+j)^0 and (-1+j)^1 of (held carry value + a_i value + b_i value). Here bit 0 of a pair has weight 1 and bit 1 has weight (-1+j).
- R4: A pair accepted with start_i high ignores the held carry, as if the carry were zero.
- R5: On a cycle with valid_i low, the held carry does not change and sum_valid_o is 0 on the following cycle.
- R6: While carry_oe_i is 0, carry_o is all zeros.
- R7: While carry_oe_i is 1, carry_o shows the carry left by the last accepted pair. Bit i has weight (-1+j)^i relative to the position just above that pair.
- R8: For operands of 2 to 16 digits, the Gaussian integer of {carry, sum pairs} equals the sum of the operands' Gaussian integers.
- R9: Operands 011111 (-2+j) and 111110 (1-3j) give sum pairs 01, 10, 10 and final carry 00000011, which reads 11101001 (-1-2j). The first pair (11 plus 10) leaves carry 00000110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Digit pair present this cycle |
| start_i | input | 1 | Pair is the least significant of a new add |
| a_i | input | 2 | Two digits of operand A, bit 0 less significant |
| b_i | input | 2 | Two digits of operand B, bit 0 less significant |
| carry_oe_i | input | 1 | Drives the held carry onto carry_o |
| sum_valid_o | output | 1 | sum_o carries a fresh result pair |
| sum_o | output | 2 | Two result digits |
| carry_o | output | 8 | Held carry pattern, zero while disabled |

## Verification
The hardest state to reach is a large carry pattern, such as 11101001 or 01110101, combined with every digit pair. These carries only appear after particular chains of earlier pairs. The bench first drives 11 plus 11 on a started add to push the carry away from zero. It then applies all sixteen pair combinations both ways round. Random adds of up to eight pairs wander through the rest of the reachable carries, and a value-level model follows every step.

// File: rtl/cbn_pkg.sv
`timescale 1ns/1ps
package cbn_pkg;
  localparam int PAIR_W   = 2;
  localparam int CARRY_W  = 8;
  localparam int STEP_W   = PAIR_W + CARRY_W;
  localparam int GROUPS   = 9;
  localparam int GRP_W    = $clog2(GROUPS);
  localparam int PC_COUNT = 1 << CARRY_W;

  typedef logic [GRP_W-1:0]   grp_t;
  typedef logic [CARRY_W-1:0] carry_t;
  typedef logic [STEP_W-1:0]  step_t;  // {next carry, sum pair}

  // value of a digit-count group, real part
  function automatic int grp_re(grp_t g);
    case (g)
      4'd1: return 1;
      4'd2: return -1;
      4'd4: return 2;
      4'd5: return 1;
      4'd6: return -2;
      4'd7: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int grp_im(grp_t g);
    case (g)
      4'd2, 4'd3, 4'd5: return 1;
      4'd6, 4'd7, 4'd8: return 2;
      default: return 0;
    endcase
  endfunction

  // carry + group value, rewritten as STEP_W canonical radix (-1+j) digits
  function automatic step_t step_calc(grp_t g, carry_t pc);
    int wr, wi, vr, vi, t, nr, ni;
    step_t r;
    wr = 1; wi = 0; vr = grp_re(g); vi = grp_im(g);
    for (int k = 0; k < CARRY_W; k++) begin
      if (pc[k]) begin
        vr += wr;
        vi += wi;
      end
      t  = -wr - wi;
      wi = wr - wi;
      wr = t;
    end
    for (int k = 0; k < STEP_W; k++) begin
      r[k] = ((vr + vi) & 1) != 0;
      vr -= int'(r[k]);
      nr = (vi - vr) >>> 1;
      ni = (-(vr + vi)) >>> 1;
      vr = nr;
      vi = ni;
    end
    return r;
  endfunction
endpackage

// File: rtl/cbn_pair_group.sv
`timescale 1ns/1ps
module cbn_pair_group
  import cbn_pkg::*;
(
  input  logic [PAIR_W-1:0] a_i,
  input  logic [PAIR_W-1:0] b_i,
  output grp_t              grp_o
);
  logic [1:0] cnt0, cnt1;

  assign cnt0 = {1'b0, a_i[0]} + {1'b0, b_i[0]};
  assign cnt1 = {1'b0, a_i[1]} + {1'b0, b_i[1]};

  always_comb begin
    case ({cnt1, cnt0})
      4'b0000: grp_o = 4'd0;
      4'b0001: grp_o = 4'd1;
      4'b0100: grp_o = 4'd2;
      4'b0101: grp_o = 4'd3;
      4'b0010: grp_o = 4'd4;
      4'b0110: grp_o = 4'd5;
      4'b1000: grp_o = 4'd6;
      4'b1001: grp_o = 4'd7;
      4'b1010: grp_o = 4'd8;
      default: grp_o = 4'd0;
    endcase
  end
endmodule

// File: rtl/cbn_step.sv
`timescale 1ns/1ps
module cbn_step
  import cbn_pkg::*;
#(
  parameter bit USE_LUT = 1'b1
) (
  input  grp_t              grp_i,
  input  carry_t            pc_i,
  output logic [PAIR_W-1:0] sum_o,
  output carry_t            nc_o
);
  step_t res;

  if (USE_LUT) begin : g_lut
    localparam int DEPTH = GROUPS * PC_COUNT;
    step_t lut [DEPTH];
    logic [GRP_W+CARRY_W-1:0] idx;
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      for (genvar c = 0; c < PC_COUNT; c++) begin : g_pc
        assign lut[g*PC_COUNT+c] = step_calc(grp_t'(g), carry_t'(c));
      end
    end
    assign idx = {grp_i, pc_i};
    assign res = (grp_i < grp_t'(GROUPS)) ? lut[idx] : '0;
  end else begin : g_logic
    always_comb res = step_calc(grp_i, pc_i);
  end

  assign sum_o = res[PAIR_W-1:0];
  assign nc_o  = res[STEP_W-1:PAIR_W];
endmodule

// File: rtl/cbn_serial_adder.sv
`timescale 1ns/1ps
module cbn_serial_adder
  import cbn_pkg::*;
#(
  parameter bit USE_LUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              start_i,
  input  logic [PAIR_W-1:0] a_i,
  input  logic [PAIR_W-1:0] b_i,
  input  logic              carry_oe_i,
  output logic              sum_valid_o,
  output logic [PAIR_W-1:0] sum_o,
  output logic [CARRY_W-1:0] carry_o
);
  grp_t              grp;
  carry_t            carry_q, pc_eff, nc;
  logic [PAIR_W-1:0] sum_d, sum_q;
  logic              vld_q;

  cbn_pair_group u_grp (
    .a_i  (a_i),
    .b_i  (b_i),
    .grp_o(grp)
  );

  // a new add starts from an empty carry
  assign pc_eff = start_i ? '0 : carry_q;

  cbn_step #(.USE_LUT(USE_LUT)) u_step (
    .grp_i(grp),
    .pc_i (pc_eff),
    .sum_o(sum_d),
    .nc_o (nc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= '0;
      sum_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        carry_q <= nc;
        sum_q   <= sum_d;
      end
    end
  end

  assign sum_valid_o = vld_q;
  assign sum_o       = sum_q;
  assign carry_o     = carry_oe_i ? carry_q : '0;
endmodule

// File: rtl/cbn_serial_adder_chk.sv
`timescale 1ns/1ps
module cbn_serial_adder_chk
  import cbn_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              start_i,
  input logic [PAIR_W-1:0] a_i,
  input logic [PAIR_W-1:0] b_i,
  input logic              sum_valid_o,
  input logic [PAIR_W-1:0] sum_o,
  input carry_t            carry_q
);
  // R3
  sum_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> sum_valid_o);

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(carry_q) && !sum_valid_o));

  // R4
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && start_i && a_i == 2'b00 && b_i == 2'b00) |=>
      (carry_q == '0 && sum_o == 2'b00));

  // R9
  first_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && start_i && a_i == 2'b11 && b_i == 2'b10) |=>
      (carry_q == 8'b0000_0110 && sum_o == 2'b01));
endmodule

bind cbn_serial_adder cbn_serial_adder_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .start_i    (start_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .sum_valid_o(sum_valid_o),
  .sum_o      (sum_o),
  .carry_q    (carry_q)
);

// File: tb/tb_cbn_serial_adder.sv
`timescale 1ns/1ps
module tb_cbn_serial_adder;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0, start_i = 1'b0, carry_oe_i = 1'b0;
  logic [1:0] a_i = '0, b_i = '0;
  logic       sum_valid_o;
  logic [1:0] sum_o;
  logic [7:0] carry_o;

  int checks = 0, fails = 0;
  int mr = 0, mi = 0;  // model carry as a Gaussian integer
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cbn_serial_adder dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .carry_oe_i(carry_oe_i),
    .sum_valid_o(sum_valid_o), .sum_o(sum_o), .carry_o(carry_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Gaussian integer of an n-digit radix (-1+j) word
  function automatic void gauss(input logic [31:0] d, input int n, output int re, output int im);
    int wr = 1, wi = 0, t;
    re = 0; im = 0;
    for (int k = 0; k < n; k++) begin
      if (d[k]) begin re += wr; im += wi; end
      t = -wr - wi; wi = wr - wi; wr = t;
    end
  endfunction

  // drive one pair (caller is at a negedge), check one cycle later
  task automatic send_pair(input bit st, input logic [1:0] a, input logic [1:0] b,
                           output logic [1:0] got);
    int vr, vi, ar, ai, br, bi, nr;
    logic [1:0] exp;
    gauss({30'd0, a}, 2, ar, ai);
    gauss({30'd0, b}, 2, br, bi);
    vr = (st ? 0 : mr) + ar + br;
    vi = (st ? 0 : mi) + ai + bi;
    for (int k = 0; k < 2; k++) begin
      exp[k] = ((vr + vi) % 2) != 0;
      vr -= int'(exp[k]);
      nr = (vi - vr) / 2;
      vi = -(vr + vi) / 2;
      vr = nr;
    end
    mr = vr; mi = vi;
    valid_i = 1'b1; start_i = st; a_i = a; b_i = b;
    @(negedge clk);
    got = sum_o;
    check(sum_valid_o == 1'b1, "R3 sum_valid", sum_valid_o, 1);
    check(sum_o == exp, "R3 sum pair", sum_o, exp);
  endtask

  task automatic idle();
    valid_i = 1'b0; start_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_carry_model(input string req);
    int cr, ci;
    carry_oe_i = 1'b1;
    #1;
    gauss({24'd0, carry_o}, 8, cr, ci);
    check(cr == mr && ci == mi, req, {cr, ci}, {mr, mi});
    carry_oe_i = 1'b0;
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [1:0] g, g2;
    logic [7:0] c1, c2;
    repeat (3) @(negedge clk);
    // R1 reset state
    carry_oe_i = 1'b1;
    #1;
    check(sum_valid_o == 1'b0, "R1 sum_valid after reset", sum_valid_o, 0);
    check(carry_o == 8'h00, "R1 carry during reset", carry_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(carry_o == 8'h00, "R1 carry after reset", carry_o, 0);
    carry_oe_i = 1'b0;

    // R9 worked example
    send_pair(1'b1, 2'b11, 2'b10, g);
    check(g == 2'b01, "R9 first pair", g, 1);
    carry_oe_i = 1'b1; #1;
    check(carry_o == 8'b0000_0110, "R9 first carry", carry_o, 8'b0000_0110);
    carry_oe_i = 1'b0;
    send_pair(1'b0, 2'b11, 2'b11, g);
    check(g == 2'b10, "R9 second pair", g, 2);
    send_pair(1'b0, 2'b01, 2'b11, g);
    check(g == 2'b10, "R9 third pair", g, 2);
    idle();
    // R6 gated bus
    check(carry_o == 8'h00, "R6 carry gated", carry_o, 0);
    carry_oe_i = 1'b1; #1;
    check(carry_o == 8'b0000_0011, "R9 final carry", carry_o, 3);
    carry_oe_i = 1'b0;
    check_carry_model("R7 carry value");

    // R5 idle cycles keep carry
    repeat (3) idle();
    check(sum_valid_o == 1'b0, "R5 no valid when idle", sum_valid_o, 0);
    check_carry_model("R5 carry held");

    // R4 start discards a nonzero carry
    send_pair(1'b1, 2'b11, 2'b11, g);
    send_pair(1'b1, 2'b00, 2'b00, g);
    check(g == 2'b00, "R4 start sum", g, 0);
    carry_oe_i = 1'b1; #1;
    check(carry_o == 8'h00, "R4 start carry", carry_o, 0);
    carry_oe_i = 1'b0;

    // R2 swap symmetry from a nonzero carry
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 4; q++) begin
        send_pair(1'b1, 2'b11, 2'b11, g);
        send_pair(1'b0, 2'(p), 2'(q), g);
        carry_oe_i = 1'b1; #1; c1 = carry_o; carry_oe_i = 1'b0;
        send_pair(1'b1, 2'b11, 2'b11, g2);
        send_pair(1'b0, 2'(q), 2'(p), g2);
        carry_oe_i = 1'b1; #1; c2 = carry_o; carry_oe_i = 1'b0;
        check(g == g2 && c1 == c2, "R2 swap", {g, c1}, {g2, c2});
      end
    end
    idle();

    // R8 random adds of 2..16 digits
    for (int t = 0; t < 60; t++) begin
      int np, ar, ai, br, bi, sr, si, cr, ci, wr, wi, tt, rr, ri;
      logic [15:0] a_w, b_w, s_w;
      np = 1 + int'($urandom % 8);
      a_w = 16'($urandom); b_w = 16'($urandom);
      if (np < 8) begin
        a_w &= 16'((1 << (2*np)) - 1);
        b_w &= 16'((1 << (2*np)) - 1);
      end
      s_w = '0;
      for (int k = 0; k < np; k++) begin
        send_pair(k == 0, a_w[2*k +: 2], b_w[2*k +: 2], g);
        s_w[2*k +: 2] = g;
        if ($urandom % 4 == 0) idle();
      end
      idle();
      check_carry_model("R7 carry after add");
      carry_oe_i = 1'b1; #1;
      gauss({16'd0, a_w}, 2*np, ar, ai);
      gauss({16'd0, b_w}, 2*np, br, bi);
      gauss({16'd0, s_w}, 2*np, sr, si);
      gauss({24'd0, carry_o}, 8, cr, ci);
      carry_oe_i = 1'b0;
      wr = 1; wi = 0;
      for (int k = 0; k < 2*np; k++) begin
        tt = -wr - wi; wi = wr - wi; wr = tt;
      end
      rr = sr + cr*wr - ci*wi;
      ri = si + cr*wi + ci*wr;
      check(rr == ar + br && ri == ai + bi, "R8 full add",
            {rr, ri}, {ar + br, ai + bi});
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule